// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor over many clock cycles. It uses one trial subtractor and does one quotient bit per cycle. Both operands can be read as unsigned or as two's-complement signed values. The quotient is returned on `lo` and the remainder on `hi`. A single-cycle `start` pulse loads the operands. `busy` stays high while the iterations run, and `done` pulses for one cycle when the results appear on `hi`/`lo`.

The datapath holds the divisor in a fixed register. A double-width working register shifts left by one place per step. Each step does a trial subtraction of the divisor from the upper half of the working register:
- If the result is negative, the old upper half is kept and a 0 shifts into the low end.
- Otherwise, the difference replaces the upper half and a 1 shifts in.

After the last step, the low half holds the quotient and the upper half holds the true remainder. Signed operation divides the magnitudes and then applies the signs. A zero divisor raises a flag, skips the iterations and leaves `hi`/`lo` untouched.

Top module: `div_restoring_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `done` and `div_zero` go low and `hi`/`lo` go to zero.
- R2: With `is_signed` = 0, an operation with a nonzero divisor gives `lo` = dividend / divisor and `hi` = dividend % divisor, both unsigned. For example, 74 / 8 gives `lo` = 9 and `hi` = 2.
- R3: With `is_signed` = 1, the quotient is truncated toward zero and its sign is the XOR of the operand sign bits (bit 31). The remainder takes the dividend's sign. For example, -7 / 2 gives `lo` = 0xFFFFFFFD and `hi` = 0xFFFFFFFF. 0x80000000 / 0xFFFFFFFF gives `lo` = 0x80000000 and `hi` = 0.
- R4: For a start accepted at clock edge E0 with a nonzero divisor, `busy` is high after each of edges E0 to E32 (33 cycles). `done` is high for exactly one cycle, after edge E33, with `busy` low at that time.
- R5: A `start` pulse while `busy` is high is ignored. The running operation finishes with the results of its own operands.
- R6: A start with a zero divisor sets `done` and `div_zero` after the next edge. `busy` never rises and `hi`/`lo` keep their previous values. `div_zero` stays high until the next accepted start with a nonzero divisor clears it.
- R7: A `start` presented in the cycle where `done` is high is accepted, and `busy` rises on that edge.
- R8: `hi` and `lo` change only on the edge that raises `done`. They hold their values while an operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| div_zero | output | 1 | Last accepted operation had a zero divisor |
| hi | output | 32 | Remainder |
| lo | output | 32 | Quotient |

## Verification
Completion and a new request can land in the same cycle. The cycle in which `done` is high is also the first idle cycle, so a `start` presented then must be taken. To provoke this, the bench waits for `done` and asserts `start` with new operands in that same cycle, then compares `hi`/`lo` against the first operation's expected values. After the edge, it expects `busy` high with `hi`/`lo` unchanged, and then the second operation's quotient 33 cycles later. Two other cases are judged the same way: a start issued mid-operation, and a zero-divisor start issued right after a normal result.

// File: rtl/div_pkg.sv
// Package: shared types for the restoring divider.
// Assumes: nothing beyond IEEE 1800-2017.
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIN  = 2'd2
    } div_state_t;
endpackage

// File: rtl/div_ctrl.sv
// Module: div_ctrl
// Sequences one division: accepts start while idle, runs WIDTH iteration
// steps, then one finish cycle that publishes results and pulses done.
// A zero divisor skips straight to done with the zero flag set.
// Assumes: divisor_zero is valid in the same cycle as start.
module div_ctrl
    import div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic divisor_zero,
    output logic busy,
    output logic done,
    output logic div_zero,
    output logic load,
    output logic step,
    output logic fin
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    div_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Decode the strobes that drive the datapath.
    always_comb begin
        busy = (state_q != ST_IDLE);
        load = start && (state_q == ST_IDLE) && !divisor_zero;
        step = (state_q == ST_STEP);
        fin  = (state_q == ST_FIN);
    end

    // State, step counter, done pulse and zero flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            done     <= 1'b0;
            div_zero <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (divisor_zero) begin
                            done     <= 1'b1;
                            div_zero <= 1'b1;
                        end else begin
                            div_zero <= 1'b0;
                            cnt_q    <= '0;
                            state_q  <= ST_STEP;
                        end
                    end
                end
                ST_STEP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_FIN;
                end
                ST_FIN: begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_ZERO_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor_zero) |=> (done && div_zero && !busy)); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q != LAST) |=> step); // R5
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R4
endmodule

// File: rtl/div_datapath.sv
// Module: div_datapath
// Holds the fixed divisor magnitude and the double-width working register.
// Each step shifts left by one, trial-subtracts the divisor from the upper
// half and keeps or restores it, shifting the quotient bit in at bit 0.
// Assumes: load and step never coincide; divisor nonzero when load is high.
module div_datapath #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             divisor_zero,
    output logic [WIDTH-1:0] quo_mag,
    output logic [WIDTH-1:0] rem_mag,
    output logic             quo_neg,
    output logic             rem_neg
);
    localparam int DW = 2 * WIDTH;

    logic [DW-1:0]    work_q;
    logic [WIDTH-1:0] dvsr_q;
    logic             a_neg, b_neg;
    logic [WIDTH-1:0] a_mag, b_mag;
    logic [WIDTH+1:0] trial;

    // Operand magnitudes and the trial difference of the shifted upper half.
    always_comb begin
        a_neg        = is_signed && dividend[WIDTH-1];
        b_neg        = is_signed && divisor[WIDTH-1];
        a_mag        = a_neg ? (~dividend + 1'b1) : dividend;
        b_mag        = b_neg ? (~divisor + 1'b1) : divisor;
        divisor_zero = (divisor == '0);
        trial        = {1'b0, work_q[DW-1:WIDTH-1]} - {2'b00, dvsr_q};
        quo_mag      = work_q[WIDTH-1:0];
        rem_mag      = work_q[DW-1:WIDTH];
    end

    // Load operands, then perform one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q  <= '0;
            dvsr_q  <= '0;
            quo_neg <= 1'b0;
            rem_neg <= 1'b0;
        end else if (load) begin
            work_q  <= {{WIDTH{1'b0}}, a_mag};
            dvsr_q  <= b_mag;
            quo_neg <= a_neg ^ b_neg;
            rem_neg <= a_neg;
        end else if (step) begin
            if (!trial[WIDTH+1])
                work_q <= {trial[WIDTH-1:0], work_q[WIDTH-2:0], 1'b1};
            else
                work_q <= {work_q[DW-2:0], 1'b0};
        end
    end

    AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (work_q[DW-1:WIDTH] < dvsr_q)); // R2
endmodule

// File: rtl/div_sign_fix.sv
// Module: div_sign_fix
// Applies the result signs to the unsigned quotient and remainder.
// Assumes: sign flags were captured with the operands.
module div_sign_fix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] quo_mag,
    input  logic [WIDTH-1:0] rem_mag,
    input  logic             quo_neg,
    input  logic             rem_neg,
    output logic [WIDTH-1:0] quo,
    output logic [WIDTH-1:0] rem
);
    // Two's-complement negate where the sign flag asks for it.
    always_comb begin
        quo = quo_neg ? (~quo_mag + 1'b1) : quo_mag;
        rem = rem_neg ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/div_restoring_unit.sv
// Module: div_restoring_unit
// Top of the sequential divider: control, datapath, sign correction and
// the result registers (hi = remainder, lo = quotient).
// Assumes: start is a level sampled each edge; only honoured while idle.
module div_restoring_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    input  logic             is_signed,
    output logic             busy,
    output logic             done,
    output logic             div_zero,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    logic             load, step, fin, divisor_zero;
    logic [WIDTH-1:0] quo_mag, rem_mag, quo, rem;
    logic             quo_neg, rem_neg;

    div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .divisor_zero(divisor_zero),
        .busy(busy), .done(done), .div_zero(div_zero),
        .load(load), .step(step), .fin(fin)
    );

    div_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .is_signed(is_signed), .dividend(dividend), .divisor(divisor),
        .divisor_zero(divisor_zero), .quo_mag(quo_mag), .rem_mag(rem_mag),
        .quo_neg(quo_neg), .rem_neg(rem_neg)
    );

    div_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .quo_mag(quo_mag), .rem_mag(rem_mag), .quo_neg(quo_neg),
        .rem_neg(rem_neg), .quo(quo), .rem(rem)
    );

    // Publish the corrected results in the finish cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= '0;
            lo <= '0;
        end else if (fin) begin
            hi <= rem;
            lo <= quo;
        end
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R4
    AST_LO_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lo) |-> done); // R8
    AST_HI_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hi) |-> done); // R8
endmodule

// File: tb/div_restoring_unit_test.sv
module div_restoring_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, div_zero;
    logic [31:0] hi, lo;
    int checks = 0;
    int errors = 0;
    int lat, bcnt;

    div_restoring_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .is_signed(is_signed), .busy(busy), .done(done),
        .div_zero(div_zero), .hi(hi), .lo(lo)
    );

    always #5 clk = ~clk;

    // Each entry: {is_signed, dividend, divisor}
    localparam int NV = 13;
    localparam logic [64:0] VECS [NV] = '{
        {1'b0, 32'd74,         32'd8},
        {1'b0, 32'hFFFFFFFF,   32'd1},
        {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF},
        {1'b0, 32'd5,          32'd7},
        {1'b0, 32'h12345678,   32'h00001000},
        {1'b0, 32'h80000000,   32'd3},
        {1'b0, 32'hDEADBEEF,   32'h00010001},
        {1'b1, 32'hFFFFFFF9,   32'd2},
        {1'b1, 32'd7,          32'hFFFFFFFE},
        {1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE},
        {1'b1, 32'h80000000,   32'hFFFFFFFF},
        {1'b1, 32'h80000000,   32'd1},
        {1'b1, 32'd0,          32'hFFFFFFFF}
    };

    function automatic logic [63:0] model(logic s, logic [31:0] a, logic [31:0] b);
        logic [31:0] ma, mb, q, r;
        ma = (s && a[31]) ? -a : a;
        mb = (s && b[31]) ? -b : b;
        q = ma / mb;
        r = ma % mb;
        if (s && (a[31] ^ b[31])) q = -q;
        if (s && a[31]) r = -r;
        return {r, q};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic s);
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b; is_signed = s;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Called at the negedge after the accepting edge; counts edges until done.
    task automatic wait_done(output int l, output int bc);
        l = 0; bc = 0;
        while (!done && l < 100) begin
            if (busy) bc++;
            @(negedge clk);
            l++;
        end
        if (!done) check(1'b0, "R4 timeout", 32'(l), 32'd33);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] e;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !div_zero, "R1 flags", {busy, done, div_zero}, 0);
        check(hi == 0 && lo == 0, "R1 hi/lo", lo, 0);
        rst_n = 1'b1;

        // Vector table: R2 unsigned, R3 signed
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i][63:32], VECS[i][31:0], VECS[i][64]);
            wait_done(lat, bcnt);
            e = model(VECS[i][64], VECS[i][63:32], VECS[i][31:0]);
            check(lo == e[31:0], VECS[i][64] ? "R3 quotient" : "R2 quotient", lo, e[31:0]);
            check(hi == e[63:32], VECS[i][64] ? "R3 remainder" : "R2 remainder", hi, e[63:32]);
        end

        // R2 worked example, R3 fixed signed examples
        issue(32'd74, 32'd8, 1'b0); wait_done(lat, bcnt);
        check(lo == 9 && hi == 2, "R2 74/8", {hi[15:0], lo[15:0]}, 32'h00020009);
        issue(32'hFFFFFFF9, 32'd2, 1'b1); wait_done(lat, bcnt);
        check(lo == 32'hFFFFFFFD && hi == 32'hFFFFFFFF, "R3 -7/2", lo, 32'hFFFFFFFD);
        issue(32'h80000000, 32'hFFFFFFFF, 1'b1); wait_done(lat, bcnt);
        check(lo == 32'h80000000 && hi == 0, "R3 min/-1", lo, 32'h80000000);

        // R4 latency, busy span, one-cycle done
        issue(32'd100, 32'd7, 1'b0); wait_done(lat, bcnt);
        check(lat == 33, "R4 latency", 32'(lat), 32'd33);
        check(bcnt == 33, "R4 busy cycles", 32'(bcnt), 32'd33);
        check(!busy, "R4 busy low at done", {31'd0, busy}, 0);
        @(negedge clk);
        check(!done, "R4 done one cycle", {31'd0, done}, 0);

        // R5 start ignored while busy
        issue(32'd1000, 32'd10, 1'b0);
        repeat (5) @(negedge clk);
        start = 1'b1; dividend = 32'd9; divisor = 32'd3;
        @(negedge clk); start = 1'b0;
        wait_done(lat, bcnt);
        check(lo == 100 && hi == 0, "R5 ignored start", lo, 32'd100);
        check(lat == 27, "R5 original timing", 32'(lat), 32'd27);

        // R6 zero divisor
        issue(32'd55, 32'd0, 1'b0);
        check(done && div_zero && !busy, "R6 flags", {done, div_zero, busy}, 3'b110);
        check(lo == 100 && hi == 0, "R6 hi/lo unchanged", lo, 32'd100);
        @(negedge clk);
        check(!done && !busy && div_zero, "R6 after", {done, busy, div_zero}, 3'b001);
        issue(32'd20, 32'd4, 1'b0); wait_done(lat, bcnt);
        check(!div_zero && lo == 5, "R6 flag cleared", lo, 32'd5);

        // R7 start in done cycle; R8 hold while running
        issue(32'd50, 32'd5, 1'b0); wait_done(lat, bcnt);
        check(lo == 10, "R7 first result", lo, 32'd10);
        start = 1'b1; dividend = 32'd81; divisor = 32'd9; is_signed = 1'b0;
        @(negedge clk); start = 1'b0;
        check(busy, "R7 accepted in done cycle", {31'd0, busy}, 1);
        repeat (10) @(negedge clk);
        check(lo == 10 && hi == 0, "R8 hold while busy", lo, 32'd10);
        wait_done(lat, bcnt);
        check(lo == 9 && hi == 0, "R7 second result", lo, 32'd9);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule